// File: doc/BRIEF.md
# Parallel Bus Master Controller

This block turns single-cycle host requests into timed bus cycles on an external asynchronous parallel bus. Before a transfer, the host sets a static configuration:

- the strobe style,
- the active level of every control line,
- how the address steps after each transfer,
- the three wait counts,
- the address multiplexing mode,
- an 8- or 16-bit data width.

The host then loads an address and issues read or write requests. While a bus cycle runs, `host_busy` is high. When it drops, the read data and the stepped address are ready.

A bus cycle has optional address phases followed by three data phases: beginning, middle and end. In the multiplexed modes, the address phases put the address on the data lines and pulse the address latch strobes. The data phases drive write data, or release the data lines for a read. The read or write strobe, or the transfer enable, is active only in the middle phase. The data bus is modelled as separate out, in and output-enable vectors.

Each chip select can instead serve as a high address line. Its address bit then takes part in stepping. When the chip select is enabled, that bit is frozen and blanked on the address lines.

Top module: `pbus_master`

## Requirements
- R1: After reset, and whenever idle, `host_busy` is 0, `bus_doe` is 0, `bus_dout` is 0, and every control pin sits at its inactive level.
- R2: Each control pin (cs1, cs2, latch-low, latch-high, rd, wr) is driven to its polarity bit when active and to the inverse of that bit when inactive. A disabled chip select stays inactive.
- R3: With `cfg_sep_strobes`=1, `bus_rd` is active only during the middle phase of a read, and `bus_wr` only during the middle phase of a write. The two are never active together.
- R4: With `cfg_sep_strobes`=0, `bus_rd` carries direction: it is active for the whole busy period of a read and inactive for a write, using `cfg_pol_rd`. `bus_wr` carries the enable: it is active in the middle phase of every transfer, using `cfg_pol_wr`.
- R5: The address loaded through `host_addr_wr` appears on `host_addr`. On the edge where `host_busy` falls, step code 01 adds 1, code 10 subtracts 1, and codes 00 and 11 leave the address unchanged. The step is 1 for both data widths.
- R6: Address bit 15 belongs to cs2 and bit 14 to cs1. When a chip select is enabled, its bit keeps its value through stepping, carries and borrows pass over it, it reads 0 on `bus_addr`, and the chip select pin is active for the whole busy period. When a chip select is disabled, its bit steps and is driven like any other address bit.
- R7: A transfer keeps `host_busy` high for A + (wb+1) + (wm+1) + (we+1) cycles. A is the number of address phases (0, 1 or 2), and wb, wm and we are the beginning, middle and end wait counts.
- R8: With mux code 00 there are no address phases. `bus_addr` carries the address, with enabled chip-select bits blanked.
- R9: With mux code 01 there is one address phase. It drives address bits 7:0 on `bus_dout[7:0]` with the latch-low strobe active. `bus_addr` carries bits 15:8 in its upper byte and 0 in its lower byte.
- R10: With mux code 10 there are two address phases. The first puts address bits 7:0 on `bus_dout[7:0]` with latch-low active. The second puts bits 15:8 there with latch-high active. `bus_addr` is 0.
- R11: With mux code 11 there is one address phase. It puts the whole address on `bus_dout` with both latch strobes active. `bus_addr` is 0.
- R12: In every address phase, and in all three data phases of a write, `bus_doe` is 1; in the data phases of a read it is 0. A write drives `host_wdata` in 16-bit mode, or its low byte zero-extended in 8-bit mode. A read samples `bus_din` in the last middle cycle only. In 8-bit mode the read result is zero-extended.
- R13: While `host_busy` is 1, new requests and address loads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sep_strobes | input | 1 | 1: separate read/write strobes; 0: direction plus enable |
| cfg_pol_rd | input | 1 | Active level of `bus_rd` |
| cfg_pol_wr | input | 1 | Active level of `bus_wr` (write strobe or enable) |
| cfg_pol_all | input | 1 | Active level of `bus_all` |
| cfg_pol_alh | input | 1 | Active level of `bus_alh` |
| cfg_pol_cs2 | input | 1 | Active level of `bus_cs2` |
| cfg_pol_cs1 | input | 1 | Active level of `bus_cs1` |
| cfg_cs2_en | input | 1 | Chip select 2 enabled (address bit 15 frozen) |
| cfg_cs1_en | input | 1 | Chip select 1 enabled (address bit 14 frozen) |
| cfg_step | input | 2 | Address step code |
| cfg_mux | input | 2 | Address multiplexing code |
| cfg_wide | input | 1 | 1: 16-bit data, 0: 8-bit data |
| cfg_wait_beg | input | WAITW | Beginning phase wait count |
| cfg_wait_mid | input | WAITW | Middle phase wait count |
| cfg_wait_end | input | WAITW | End phase wait count |
| host_addr_wr | input | 1 | Load `host_addr_val` into the address register |
| host_addr_val | input | DW | Address to load |
| host_req | input | 1 | Start a transfer |
| host_write | input | 1 | 1: write, 0: read |
| host_wdata | input | DW | Write data |
| host_busy | output | 1 | Transfer in progress |
| host_rdata | output | DW | Last read result |
| host_addr | output | DW | Current address register |
| bus_addr | output | DW | Address lines |
| bus_cs2 | output | 1 | Chip select 2 pin |
| bus_cs1 | output | 1 | Chip select 1 pin |
| bus_all | output | 1 | Address latch low strobe |
| bus_alh | output | 1 | Address latch high strobe |
| bus_rd | output | 1 | Read strobe or direction |
| bus_wr | output | 1 | Write strobe or enable |
| bus_dout | output | DW | Data lines, driven value |
| bus_doe | output | 1 | Data lines output enable |
| bus_din | input | DW | Data lines, sampled value |

## Verification
A wrong phase or wait count shows at the pins in the first cycle where it is wrong. The strobe, latch or output-enable level, or the byte on the data lines, differs from the cycle map the bench builds from the configuration, and `host_busy` falls too early or too late. A wrong carry path in the address stepper shows on `host_addr` at the first negative edge after busy falls, and on `bus_addr` during the following transfer. A read that samples in the wrong cycle returns one of the garbage values the bench puts on `bus_din` in every cycle except the last middle cycle.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ALO  = 3'd1,
        PH_AHI  = 3'd2,
        PH_BEG  = 3'd3,
        PH_MID  = 3'd4,
        PH_END  = 3'd5
    } phase_e;

    localparam logic [1:0] MUX_NONE   = 2'b00;
    localparam logic [1:0] MUX_PART   = 2'b01;
    localparam logic [1:0] MUX_FULL8  = 2'b10;
    localparam logic [1:0] MUX_FULL16 = 2'b11;

    localparam logic [1:0] STEP_UP    = 2'b01;
    localparam logic [1:0] STEP_DOWN  = 2'b10;

    function automatic logic pin_level(input logic act, input logic pol);
        return act ? pol : ~pol;
    endfunction

endpackage

// File: rtl/pbus_addr.sv
module pbus_addr
    import pbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          step_en,
    input  logic [1:0]    step_mode,
    input  logic          cs2_en,
    input  logic          cs1_en,
    output logic [DW-1:0] addr_q
);
    localparam int CS2_BIT = DW - 1;
    localparam int CS1_BIT = DW - 2;

    logic [DW-1:0] addr_d;
    logic [DW-1:0] part_m;
    logic [DW-1:0] up_v;
    logic [DW-1:0] dn_v;

    always_comb begin
        part_m = '1;
        if (cs2_en) part_m[CS2_BIT] = 1'b0;
        if (cs1_en) part_m[CS1_BIT] = 1'b0;
        // holes filled with ones let a carry ripple across them
        up_v = (addr_q | ~part_m) + {{(DW-1){1'b0}}, 1'b1};
        // holes filled with zeros let a borrow ripple across them
        dn_v = (addr_q & part_m) - {{(DW-1){1'b0}}, 1'b1};
        addr_d = addr_q;
        if (load) begin
            addr_d = load_val;
        end else if (step_en) begin
            case (step_mode)
                STEP_UP:   addr_d = (up_v & part_m) | (addr_q & ~part_m);
                STEP_DOWN: addr_d = (dn_v & part_m) | (addr_q & ~part_m);
                default:   addr_d = addr_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    // R5: reserved and zero step codes leave the address alone
    a_r5_hold_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && step_mode != STEP_UP && step_mode != STEP_DOWN)
        |=> $stable(addr_q));

    // R6: an enabled chip select freezes its address bit through stepping
    a_r6_cs2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && cs2_en) |=> addr_q[CS2_BIT] == $past(addr_q[CS2_BIT]));

    a_r6_cs1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && cs1_en) |=> addr_q[CS1_BIT] == $past(addr_q[CS1_BIT]));

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int DW    = 16,
    parameter int WAITW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic [DW-1:0]    wdata,
    input  logic [1:0]       mux,
    input  logic             wide,
    input  logic [WAITW-1:0] wait_beg,
    input  logic [WAITW-1:0] wait_mid,
    input  logic [WAITW-1:0] wait_end,
    input  logic [DW-1:0]    din,
    output phase_e           phase,
    output logic             wr_q,
    output logic [DW-1:0]    wd_q,
    output logic [DW-1:0]    rdata,
    output logic             busy,
    output logic             done
);
    localparam int HW = DW / 2;
    localparam logic [WAITW-1:0] CNT_ONE = {{(WAITW-1){1'b0}}, 1'b1};

    typedef struct packed {
        phase_e           ph;
        logic [WAITW-1:0] cnt;
        logic             wr;
        logic [DW-1:0]    wd;
        logic [DW-1:0]    rd;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (req) begin
                    s_d.wr  = req_write;
                    s_d.wd  = wdata;
                    s_d.cnt = '0;
                    s_d.ph  = (mux == MUX_NONE) ? PH_BEG : PH_ALO;
                end
            end
            PH_ALO: s_d.ph = (mux == MUX_FULL8) ? PH_AHI : PH_BEG;
            PH_AHI: s_d.ph = PH_BEG;
            PH_BEG: begin
                if (s_q.cnt == wait_beg) begin
                    s_d.ph  = PH_MID;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_ONE;
                end
            end
            PH_MID: begin
                if (s_q.cnt == wait_mid) begin
                    s_d.ph  = PH_END;
                    s_d.cnt = '0;
                    if (!s_q.wr) begin
                        s_d.rd = wide ? din : {{HW{1'b0}}, din[HW-1:0]};
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CNT_ONE;
                end
            end
            PH_END: begin
                if (s_q.cnt == wait_end) begin
                    s_d.ph  = PH_IDLE;
                    s_d.cnt = '0;
                    done    = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_ONE;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase = s_q.ph;
    assign wr_q  = s_q.wr;
    assign wd_q  = s_q.wd;
    assign rdata = s_q.rd;
    assign busy  = (s_q.ph != PH_IDLE);

    // R13: the transfer direction is fixed for the whole busy period
    a_r13_dir_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(s_q.wr));

    // R7: the middle phase is entered only from the beginning phase
    a_r7_mid_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_MID && $past(s_q.ph) != PH_MID) |-> $past(s_q.ph) == PH_BEG);

    // R12: read data changes only on leaving the middle phase
    a_r12_capture_point: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.rd) |-> $past(s_q.ph) == PH_MID);

endmodule

// File: rtl/pbus_drive.sv
module pbus_drive
    import pbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  logic          wr,
    input  logic [DW-1:0] wd,
    input  logic [DW-1:0] addr,
    input  logic          sep,
    input  logic          pol_rd,
    input  logic          pol_wr,
    input  logic          pol_all,
    input  logic          pol_alh,
    input  logic          pol_cs2,
    input  logic          pol_cs1,
    input  logic          cs2_en,
    input  logic          cs1_en,
    input  logic [1:0]    mux,
    input  logic          wide,
    output logic [DW-1:0] bus_addr,
    output logic          bus_cs2,
    output logic          bus_cs1,
    output logic          bus_all,
    output logic          bus_alh,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe
);
    localparam int HW = DW / 2;

    logic [DW-1:0] ma;
    logic active, data_ph, rd_act, wr_act, all_act, alh_act;

    always_comb begin
        ma = addr;
        if (cs2_en) ma[DW-1] = 1'b0;
        if (cs1_en) ma[DW-2] = 1'b0;

        active  = (phase != PH_IDLE);
        data_ph = (phase == PH_BEG) || (phase == PH_MID) || (phase == PH_END);
        all_act = (phase == PH_ALO);
        alh_act = (phase == PH_AHI) || ((phase == PH_ALO) && (mux == MUX_FULL16));

        if (sep) begin
            rd_act = (phase == PH_MID) && !wr;
            wr_act = (phase == PH_MID) && wr;
        end else begin
            rd_act = active && !wr;
            wr_act = (phase == PH_MID);
        end

        bus_all = pin_level(all_act, pol_all);
        bus_alh = pin_level(alh_act, pol_alh);
        bus_rd  = pin_level(rd_act, pol_rd);
        bus_wr  = pin_level(wr_act, pol_wr);
        bus_cs2 = pin_level(active && cs2_en, pol_cs2);
        bus_cs1 = pin_level(active && cs1_en, pol_cs1);

        case (mux)
            MUX_NONE: bus_addr = ma;
            MUX_PART: bus_addr = {ma[DW-1:HW], {HW{1'b0}}};
            default:  bus_addr = '0;
        endcase

        bus_doe  = 1'b0;
        bus_dout = '0;
        case (phase)
            PH_ALO: begin
                bus_doe  = 1'b1;
                bus_dout = (mux == MUX_FULL16) ? ma : {{HW{1'b0}}, ma[HW-1:0]};
            end
            PH_AHI: begin
                bus_doe  = 1'b1;
                bus_dout = {{HW{1'b0}}, ma[DW-1:HW]};
            end
            default: begin
                if (data_ph && wr) begin
                    bus_doe  = 1'b1;
                    bus_dout = wide ? wd : {{HW{1'b0}}, wd[HW-1:0]};
                end
            end
        endcase
    end

    // R3: separate strobes are never active together
    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        sep |-> !(rd_act && wr_act));

    // R12: the data lines are released in the data phases of a read
    a_r12_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ph && !wr) |-> !bus_doe);

    // R1: the latch strobes rest at their inactive level while idle
    a_r1_idle_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (bus_all == ~pol_all) && (bus_alh == ~pol_alh));

endmodule

// File: rtl/pbus_master.sv
module pbus_master
    import pbus_pkg::*;
#(
    parameter int DW    = 16,
    parameter int WAITW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sep_strobes,
    input  logic             cfg_pol_rd,
    input  logic             cfg_pol_wr,
    input  logic             cfg_pol_all,
    input  logic             cfg_pol_alh,
    input  logic             cfg_pol_cs2,
    input  logic             cfg_pol_cs1,
    input  logic             cfg_cs2_en,
    input  logic             cfg_cs1_en,
    input  logic [1:0]       cfg_step,
    input  logic [1:0]       cfg_mux,
    input  logic             cfg_wide,
    input  logic [WAITW-1:0] cfg_wait_beg,
    input  logic [WAITW-1:0] cfg_wait_mid,
    input  logic [WAITW-1:0] cfg_wait_end,
    input  logic             host_addr_wr,
    input  logic [DW-1:0]    host_addr_val,
    input  logic             host_req,
    input  logic             host_write,
    input  logic [DW-1:0]    host_wdata,
    output logic             host_busy,
    output logic [DW-1:0]    host_rdata,
    output logic [DW-1:0]    host_addr,
    output logic [DW-1:0]    bus_addr,
    output logic             bus_cs2,
    output logic             bus_cs1,
    output logic             bus_all,
    output logic             bus_alh,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic [DW-1:0]    bus_dout,
    output logic             bus_doe,
    input  logic [DW-1:0]    bus_din
);
    phase_e        phase;
    logic          wr_q, done, busy;
    logic [DW-1:0] wd_q;

    pbus_seq #(.DW(DW), .WAITW(WAITW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req(host_req), .req_write(host_write), .wdata(host_wdata),
        .mux(cfg_mux), .wide(cfg_wide),
        .wait_beg(cfg_wait_beg), .wait_mid(cfg_wait_mid), .wait_end(cfg_wait_end),
        .din(bus_din),
        .phase(phase), .wr_q(wr_q), .wd_q(wd_q), .rdata(host_rdata),
        .busy(busy), .done(done)
    );

    pbus_addr #(.DW(DW)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load(host_addr_wr && !busy), .load_val(host_addr_val),
        .step_en(done), .step_mode(cfg_step),
        .cs2_en(cfg_cs2_en), .cs1_en(cfg_cs1_en),
        .addr_q(host_addr)
    );

    pbus_drive #(.DW(DW)) u_drive (
        .clk(clk), .rst_n(rst_n),
        .phase(phase), .wr(wr_q), .wd(wd_q), .addr(host_addr),
        .sep(cfg_sep_strobes),
        .pol_rd(cfg_pol_rd), .pol_wr(cfg_pol_wr),
        .pol_all(cfg_pol_all), .pol_alh(cfg_pol_alh),
        .pol_cs2(cfg_pol_cs2), .pol_cs1(cfg_pol_cs1),
        .cs2_en(cfg_cs2_en), .cs1_en(cfg_cs1_en),
        .mux(cfg_mux), .wide(cfg_wide),
        .bus_addr(bus_addr), .bus_cs2(bus_cs2), .bus_cs1(bus_cs1),
        .bus_all(bus_all), .bus_alh(bus_alh),
        .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_dout(bus_dout), .bus_doe(bus_doe)
    );

    assign host_busy = busy;

    // R13: an address load while busy does not disturb the address
    a_r13_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(host_addr));

endmodule

// File: tb/pbus_master_test.sv
module pbus_master_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_sep_strobes = 1'b1, cfg_pol_rd = 1'b0, cfg_pol_wr = 1'b0;
    logic cfg_pol_all = 1'b1, cfg_pol_alh = 1'b1, cfg_pol_cs2 = 1'b0, cfg_pol_cs1 = 1'b0;
    logic cfg_cs2_en = 1'b0, cfg_cs1_en = 1'b0, cfg_wide = 1'b1;
    logic [1:0] cfg_step = 2'b00, cfg_mux = 2'b00;
    logic [3:0] cfg_wait_beg = '0, cfg_wait_mid = '0, cfg_wait_end = '0;
    logic host_addr_wr = 1'b0, host_req = 1'b0, host_write = 1'b0;
    logic [15:0] host_addr_val = '0, host_wdata = '0, bus_din = '0;
    logic host_busy, bus_cs2, bus_cs1, bus_all, bus_alh, bus_rd, bus_wr, bus_doe;
    logic [15:0] host_rdata, host_addr, bus_addr, bus_dout;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] exp_addr = '0;
    logic [15:0] exp_rdata = '0;

    pbus_master uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_sep_strobes(cfg_sep_strobes), .cfg_pol_rd(cfg_pol_rd), .cfg_pol_wr(cfg_pol_wr),
        .cfg_pol_all(cfg_pol_all), .cfg_pol_alh(cfg_pol_alh),
        .cfg_pol_cs2(cfg_pol_cs2), .cfg_pol_cs1(cfg_pol_cs1),
        .cfg_cs2_en(cfg_cs2_en), .cfg_cs1_en(cfg_cs1_en),
        .cfg_step(cfg_step), .cfg_mux(cfg_mux), .cfg_wide(cfg_wide),
        .cfg_wait_beg(cfg_wait_beg), .cfg_wait_mid(cfg_wait_mid), .cfg_wait_end(cfg_wait_end),
        .host_addr_wr(host_addr_wr), .host_addr_val(host_addr_val),
        .host_req(host_req), .host_write(host_write), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_rdata(host_rdata), .host_addr(host_addr),
        .bus_addr(bus_addr), .bus_cs2(bus_cs2), .bus_cs1(bus_cs1),
        .bus_all(bus_all), .bus_alh(bus_alh), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // the address after one step, built bit by bit from the participating positions
    function automatic logic [15:0] step_ref(input logic [15:0] a, input logic [1:0] m,
                                             input logic c1, input logic c2);
        logic [15:0] v = '0;
        logic [15:0] r = a;
        int n = 0;
        for (int i = 0; i < 16; i++) begin
            if (!((i == 15 && c2) || (i == 14 && c1))) begin
                v[n] = a[i];
                n++;
            end
        end
        if (m == 2'b01) v = v + 16'd1;
        else if (m == 2'b10) v = v - 16'd1;
        n = 0;
        for (int i = 0; i < 16; i++) begin
            if (!((i == 15 && c2) || (i == 14 && c1))) begin
                r[i] = v[n];
                n++;
            end
        end
        return r;
    endfunction

    function automatic logic lv(input logic act, input logic pol);
        return act ? pol : ~pol;
    endfunction

    // phase codes: 0 idle, 1 addr low, 2 addr high, 3 beginning, 4 middle, 5 end
    function automatic logic [38:0] exp_pins(input int p, input logic wr, input logic [15:0] wd,
                                             input logic [15:0] a);
        logic [15:0] ma = a;
        logic rd_a, wr_a, doe;
        logic [15:0] dout, ba;
        if (cfg_cs2_en) ma[15] = 1'b0;
        if (cfg_cs1_en) ma[14] = 1'b0;
        if (cfg_sep_strobes) begin
            rd_a = (p == 4) && !wr;
            wr_a = (p == 4) && wr;
        end else begin
            rd_a = (p != 0) && !wr;
            wr_a = (p == 4);
        end
        doe = 1'b0;
        dout = '0;
        if (p == 1) begin
            doe = 1'b1;
            dout = (cfg_mux == 2'b11) ? ma : {8'h00, ma[7:0]};
        end else if (p == 2) begin
            doe = 1'b1;
            dout = {8'h00, ma[15:8]};
        end else if (p >= 3 && wr) begin
            doe = 1'b1;
            dout = cfg_wide ? wd : {8'h00, wd[7:0]};
        end
        ba = (cfg_mux == 2'b00) ? ma : (cfg_mux == 2'b01) ? {ma[15:8], 8'h00} : 16'h0000;
        return {lv((p != 0) && cfg_cs1_en, cfg_pol_cs1), lv((p != 0) && cfg_cs2_en, cfg_pol_cs2),
                lv(p == 1, cfg_pol_all), lv((p == 2) || (p == 1 && cfg_mux == 2'b11), cfg_pol_alh),
                lv(rd_a, cfg_pol_rd), lv(wr_a, cfg_pol_wr), doe, dout, ba};
    endfunction

    function automatic logic [38:0] act_pins();
        return {bus_cs1, bus_cs2, bus_all, bus_alh, bus_rd, bus_wr, bus_doe, bus_dout, bus_addr};
    endfunction

    function automatic string pin_tag(input logic [38:0] a, input logic [38:0] e, input int p);
        if (a[34:33] !== e[34:33]) return cfg_sep_strobes ? "R3" : "R4";
        if (a[38:37] !== e[38:37]) return "R6";
        if (p == 1 || p == 2 || a[15:0] !== e[15:0]) begin
            case (cfg_mux)
                2'b00: return "R8";
                2'b01: return "R9";
                2'b10: return "R10";
                default: return "R11";
            endcase
        end
        if (a[32:16] !== e[32:16]) return "R12";
        return "R2";
    endfunction

    task automatic set_addr(input logic [15:0] v);
        @(negedge clk);
        host_addr_wr = 1'b1;
        host_addr_val = v;
        @(negedge clk);
        host_addr_wr = 1'b0;
        exp_addr = v;
        chk("R5 address load", {48'h0, host_addr}, {48'h0, v});
    endtask

    task automatic run_txn(input logic wr, input logic [15:0] wd, input logic [15:0] din_ok,
                           input logic inject, input string addr_tag);
        int naddr, total, lastmid, p;
        logic [38:0] e, a;
        naddr = (cfg_mux == 2'b00) ? 0 : (cfg_mux == 2'b10) ? 2 : 1;
        total = naddr + int'(cfg_wait_beg) + int'(cfg_wait_mid) + int'(cfg_wait_end) + 3;
        lastmid = naddr + int'(cfg_wait_beg) + 1 + int'(cfg_wait_mid);
        @(negedge clk);
        host_req = 1'b1;
        host_write = wr;
        host_wdata = wd;
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            bus_din = (k == lastmid) ? din_ok : 16'($urandom);
            if (k < naddr) p = (k == 0) ? 1 : 2;
            else if (k < naddr + int'(cfg_wait_beg) + 1) p = 3;
            else if (k <= lastmid) p = 4;
            else p = 5;
            chk("R7 busy during transfer", {63'h0, host_busy}, 64'h1);
            e = exp_pins(p, wr, wd, exp_addr);
            a = act_pins();
            chk(pin_tag(a, e, p), {25'h0, a}, {25'h0, e});
            if (k == 0) begin
                host_req = inject;
                host_write = ~wr;
                host_wdata = ~wd;
                host_addr_wr = inject;
                host_addr_val = 16'($urandom);
            end else if (k == 1) begin
                host_req = 1'b0;
                host_addr_wr = 1'b0;
            end
        end
        @(negedge clk);
        chk("R7 busy released", {63'h0, host_busy}, 64'h0);
        exp_addr = step_ref(exp_addr, cfg_step, cfg_cs1_en, cfg_cs2_en);
        chk(addr_tag, {48'h0, host_addr}, {48'h0, exp_addr});
        if (!wr) exp_rdata = cfg_wide ? din_ok : {8'h00, din_ok[7:0]};
        chk("R12 read data", {48'h0, host_rdata}, {48'h0, exp_rdata});
        chk("R1 idle pins", {25'h0, act_pins()}, {25'h0, exp_pins(0, 1'b0, 16'h0, exp_addr)});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy after reset", {63'h0, host_busy}, 64'h0);
        chk("R1 pins after reset", {25'h0, act_pins()}, {25'h0, exp_pins(0, 1'b0, 16'h0, 16'h0)});

        // R3 and R8: demultiplexed write, separate strobes, increment
        set_addr(16'h1234);
        cfg_step = 2'b01;
        run_txn(1'b1, 16'hBEEF, 16'h0, 1'b0, "R5 increment");

        // R4: combined direction/enable, 16-bit read with waits
        cfg_sep_strobes = 1'b0; cfg_wait_beg = 4'd2; cfg_wait_mid = 4'd3; cfg_wait_end = 4'd1;
        run_txn(1'b0, 16'h0, 16'hA5C3, 1'b0, "R5 increment");

        // R6: cs1 enabled, carry skips bit 14 into bit 15
        cfg_cs1_en = 1'b1; cfg_cs2_en = 1'b0;
        set_addr(16'h3FFF);
        run_txn(1'b1, 16'h0102, 16'h0, 1'b0, "R6 carry over cs1 bit");
        chk("R6 expected wrap value", {48'h0, host_addr}, 64'h8000);

        // R6: both enabled, borrow wraps within bits 13:0
        cfg_cs2_en = 1'b1; cfg_step = 2'b10;
        set_addr(16'h0000);
        run_txn(1'b0, 16'h0, 16'h1111, 1'b0, "R6 borrow with both cs");
        chk("R6 expected borrow value", {48'h0, host_addr}, 64'h3FFF);

        // R5: reserved step code holds; R10 two-phase mux, 8-bit read zero extension (R12)
        cfg_cs1_en = 1'b0; cfg_cs2_en = 1'b0; cfg_step = 2'b11; cfg_mux = 2'b10; cfg_wide = 1'b0;
        set_addr(16'hC3A5);
        run_txn(1'b0, 16'h0, 16'hFE7D, 1'b0, "R5 reserved code holds");

        // R13: request and address load during busy are ignored; R9, R11
        cfg_step = 2'b00; cfg_mux = 2'b01; cfg_wide = 1'b1;
        run_txn(1'b1, 16'h5A5A, 16'h0, 1'b1, "R13 busy ignores load");
        cfg_mux = 2'b11;
        run_txn(1'b0, 16'h0, 16'h7E81, 1'b1, "R13 busy ignores load");

        for (int t = 0; t < 300; t++) begin
            logic [31:0] r;
            r = $urandom;
            cfg_sep_strobes = r[0]; cfg_pol_rd = r[1]; cfg_pol_wr = r[2];
            cfg_pol_all = r[3]; cfg_pol_alh = r[4]; cfg_pol_cs2 = r[5]; cfg_pol_cs1 = r[6];
            cfg_cs2_en = r[7]; cfg_cs1_en = r[8]; cfg_step = r[10:9]; cfg_mux = r[12:11];
            cfg_wide = r[13]; cfg_wait_beg = r[17:14]; cfg_wait_mid = r[21:18];
            cfg_wait_end = r[25:22];
            if (r[26]) set_addr(16'($urandom));
            run_txn(r[27], 16'($urandom), 16'($urandom), r[28], "R5 random step");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule